// File: doc/BRIEF.md
# Flow-Through Burst SRAM Access Controller

This block sits behind the pins of a synchronous flow-through burst cache SRAM and decides, on every rising clock edge, what kind of cycle is taking place. There are five kinds: deselect, begin-burst read, begin-burst write, continue burst and suspend burst. It then carries the cycle out on a small internal memory. Each word of that memory is made of four 8-bit lanes, and each lane has its own parity bit. A two-bit burst counter generates the word address inside a four-word group. The counter steps in either linear or interleaved order.

The memory is flow-through. Read data appears combinationally from the address registered at the most recent edge, and no output register sits in the path. The bidirectional data bus is modelled as a split pair: `wrData` is the value seen on the pins, and `rdData` together with `busDrive` is what the block would drive back. Writes that start on the processor strobe are pushed to the following edge. Writes that start on the controller strobe take effect at the edge that starts them.

Top module: `fts_top`

## Requirements
- R1: While `rstN` is low, and after reset until a burst has begun, `busDrive` stays 0. A continue cycle with no burst open has no effect.
- R2: A strobe is recognised when `adscN` is low, or when `adspN` and `ce1N` are both low. A recognised strobe while any enable is inactive (`ce1N` high, `ce2` low or `ce3N` high) is a deselect. After it `busDrive` is 0, and the continue cycles that follow also leave it 0.
- R3: `adspN` low with `ce1N` high is ignored. If `adscN` is also high, the cycle is treated as a continue or suspend of the open burst.
- R4: A begin cycle on `adspN` is always a read, whatever `gwN`, `bweN` and `bwN` say. Memory is unchanged and the word at the presented address is returned.
- R5: A begin cycle on `adscN` with `adspN` high is a write when the write inputs request one. The word is written at the presented address at that same edge. When both strobes are low, `adspN` wins and the cycle is a read.
- R6: `gwN` low writes all four lanes and all four parity bits, whatever `bweN` and `bwN` are.
- R7: With `gwN` high and `bweN` low, lane n is written only when `bwN[n]` is low. Lane n is `wrData[8n+7:8n]` plus parity bit `wrData[32+n]`. The other lanes keep their contents.
- R8: With `gwN` high, the cycle is a read when `bweN` is high or when all of `bwN` are high.
- R9: After any write edge, including a partial byte write, `busDrive` is 0 even when `oeN` is low.
- R10: After a read edge, `busDrive` follows `oeN` without waiting for a clock (it is 1 exactly when `oeN` is low). `rdData` is then the word at the address registered at that edge.
- R11: In a continue cycle (`advN` low) the address steps within its four-word group. With `modeIlv` low the order is linear: the low two bits go start, start+1, start+2, start+3, modulo 4.
- R12: With `modeIlv` high the order is interleaved: the low two bits are start XOR beat, for beat 0 to 3. The sequence wraps back to the start after the fourth beat.
- R13: In a suspend cycle (`advN` high, no strobe) the address is held. A write in a suspend cycle writes that same word.
- R14: In a continue cycle, a write request writes the stepped address at that edge. This is how a burst opened on `adspN` performs its deferred write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ce1N | input | 1 | Chip enable, active low; also gates `adspN` |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte write enable, active low |
| bwN | input | 4 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| modeIlv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | 6 | Word address presented with a strobe |
| wrData | input | 36 | Bus value sampled on write edges (bits 31:0 data, 35:32 parity) |
| rdData | output | 36 | Read word driven back while `busDrive` is 1, otherwise 0 |
| busDrive | output | 1 | Bus driver enable for the bidirectional data pins |

## Verification
Write effects and the address registered at an edge are both due at that edge. The bench drives every input two nanoseconds after a rising edge and samples `rdData` and `busDrive` two nanoseconds after the next edge, which is the first instant the new cycle's result exists. The output-enable checks toggle `oeN` between edges and sample one nanosecond later, with no clock in between, because that path has no register. Each write is confirmed by a later read cycle of the same word, so the write and its read-back are judged at two separate edges.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Cycle kinds decoded at each rising edge
  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_BURST_RD,
    CYC_BURST_WR
  } cyc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } dp_strobe_t;

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl #(
  parameter int BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [BYTES-1:0]        bwN,
  output logic                    loadAddr,
  output logic                    advance,
  output fts_pkg::dp_strobe_t     dpStrb,
  output logic [BYTES-1:0]        wrMask
);
  import fts_pkg::*;

  logic enAll, adspSeen, strobeSeen, wrReq, burstOpen;
  logic [BYTES-1:0] laneReq;
  cyc_e cyc;

  assign enAll      = !ce1N && ce2 && !ce3N;
  assign adspSeen   = !adspN && !ce1N;
  assign strobeSeen = adspSeen || !adscN;

  // Global write overrides lane selects
  always_comb begin
    if (!gwN)       laneReq = '1;
    else if (!bweN) laneReq = ~bwN;
    else            laneReq = '0;
  end
  assign wrReq = |laneReq;

  always_comb begin
    cyc = CYC_NONE;
    if (strobeSeen) begin
      if (!enAll)       cyc = CYC_DESEL;
      else if (adspSeen) cyc = CYC_BEGIN_RD;
      else if (wrReq)   cyc = CYC_BEGIN_WR;
      else              cyc = CYC_BEGIN_RD;
    end else if (burstOpen) begin
      cyc = wrReq ? CYC_BURST_WR : CYC_BURST_RD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           burstOpen <= 1'b0;
    else if (strobeSeen) burstOpen <= enAll;
  end

  assign loadAddr    = (cyc == CYC_BEGIN_RD) || (cyc == CYC_BEGIN_WR);
  assign advance     = ((cyc == CYC_BURST_RD) || (cyc == CYC_BURST_WR)) && !advN;
  assign dpStrb.wrEn = (cyc == CYC_BEGIN_WR) || (cyc == CYC_BURST_WR);
  assign dpStrb.rdEn = (cyc == CYC_BEGIN_RD) || (cyc == CYC_BURST_RD);
  assign wrMask      = dpStrb.wrEn ? laneReq : '0;

endmodule

// File: rtl/fts_burst.sv
module fts_burst #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeIlv,
  input  logic              loadAddr,
  input  logic              advance,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  baseHi;
  logic [CNT_W-1:0] startLo, beat, beatNext;

  function automatic logic [CNT_W-1:0] orderLo(input logic ilv,
                                               input logic [CNT_W-1:0] s,
                                               input logic [CNT_W-1:0] k);
    return ilv ? (s ^ k) : (s + k);
  endfunction

  assign beatNext = beat + {{(CNT_W-1){1'b0}}, 1'b1};
  assign curAddr  = {baseHi, orderLo(modeIlv, startLo, beat)};

  always_comb begin
    if (loadAddr)     nextAddr = addrIn;
    else if (advance) nextAddr = {baseHi, orderLo(modeIlv, startLo, beatNext)};
    else              nextAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi  <= '0;
      startLo <= '0;
      beat    <= '0;
    end else if (loadAddr) begin
      {baseHi, startLo} <= addrIn;
      beat              <= '0;
    end else if (advance) begin
      beat <= beatNext;
    end
  end

endmodule

// File: rtl/fts_data.sv
module fts_data #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fts_pkg::dp_strobe_t         dpStrb,
  input  logic [BYTES-1:0]            wrMask,
  input  logic [ADDR_W-1:0]           curAddr,
  input  logic [ADDR_W-1:0]           nextAddr,
  input  logic [BYTES*(BYTE_W+1)-1:0] wrData,
  input  logic                        oeN,
  output logic [BYTES*(BYTE_W+1)-1:0] rdData,
  output logic                        busDrive
);
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int WORD_W = DATA_W + BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] word;
  logic              readValid;

  // One storage array per lane: data byte plus its parity bit
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (dpStrb.wrEn && wrMask[g])
        laneMem[nextAddr] <= {wrData[DATA_W+g], wrData[g*BYTE_W +: BYTE_W]};
    end
    assign word[g*BYTE_W +: BYTE_W] = laneMem[curAddr][BYTE_W-1:0];
    assign word[DATA_W+g]           = laneMem[curAddr][BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readValid <= 1'b0;
    else       readValid <= dpStrb.rdEn;
  end

  assign busDrive = readValid && !oeN;
  assign rdData   = busDrive ? word : '0;

endmodule

// File: rtl/fts_top.sv
module fts_top #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ce1N,
  input  logic                        ce2,
  input  logic                        ce3N,
  input  logic                        adspN,
  input  logic                        adscN,
  input  logic                        advN,
  input  logic                        gwN,
  input  logic                        bweN,
  input  logic [BYTES-1:0]            bwN,
  input  logic                        oeN,
  input  logic                        modeIlv,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTES*(BYTE_W+1)-1:0] wrData,
  output logic [BYTES*(BYTE_W+1)-1:0] rdData,
  output logic                        busDrive
);
  fts_pkg::dp_strobe_t dpStrb;
  logic [BYTES-1:0]    wrMask;
  logic                loadAddr, advance;
  logic [ADDR_W-1:0]   curAddr, nextAddr;

  fts_ctrl #(.BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .loadAddr(loadAddr), .advance(advance),
    .dpStrb(dpStrb), .wrMask(wrMask)
  );

  fts_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst (
    .clk(clk), .rstN(rstN), .addrIn(addr), .modeIlv(modeIlv),
    .loadAddr(loadAddr), .advance(advance),
    .curAddr(curAddr), .nextAddr(nextAddr)
  );

  fts_data #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .dpStrb(dpStrb), .wrMask(wrMask),
    .curAddr(curAddr), .nextAddr(nextAddr), .wrData(wrData), .oeN(oeN),
    .rdData(rdData), .busDrive(busDrive)
  );

endmodule

// File: rtl/fts_chk.sv
module fts_chk (
  input logic clk,
  input logic rstN,
  input logic ce1N,
  input logic ce2,
  input logic ce3N,
  input logic adspN,
  input logic adscN,
  input logic gwN,
  input logic oeN,
  input logic busDrive
);
  logic enAll, strobeSeen;
  assign enAll      = !ce1N && ce2 && !ce3N;
  assign strobeSeen = !adscN || (!adspN && !ce1N);

  // R1
  always @(negedge clk) begin
    if (!rstN) reset_quiet_chk: assert (!busDrive);
  end

  // R10
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> !oeN);

  // R4
  adsp_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && enAll) |=> (oeN || busDrive));

  // R9
  write_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && !adscN && !gwN && enAll) |=> !busDrive);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeSeen && !enAll) |=> !busDrive);

endmodule

bind fts_top fts_chk u_fts_chk (
  .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
  .adspN(adspN), .adscN(adscN), .gwN(gwN), .oeN(oeN), .busDrive(busDrive)
);

// File: tb/test_fts_top.sv
module test_fts_top;
  logic clk = 1'b0;
  logic rstN, ce1N, ce2, ce3N, adspN, adscN, advN, gwN, bweN, oeN, modeIlv;
  logic [3:0]  bwN;
  logic [5:0]  addr;
  logic [35:0] wrData, rdData;
  logic        busDrive;
  logic [35:0] refMem [64];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fts_top i_fts_top (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .modeIlv(modeIlv), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busDrive(busDrive)
  );

  function automatic logic [35:0] pattern(input int i);
    logic [7:0] b = 8'(i);
    return {b[3:0] ^ 4'h5, b * 8'd17 + 8'd3, ~b, b + 8'h40, b * 8'd3};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readChk(input string req, input int a);
    chk(req, {35'd0, busDrive}, 36'd1);
    chk(req, rdData, refMem[a]);
  endtask

  task automatic idle();
    ce1N = 0; ce2 = 1; ce3N = 0; adspN = 1; adscN = 1; advN = 1;
    gwN = 1; bweN = 1; bwN = 4'hF; oeN = 0; modeIlv = 0; addr = '0; wrData = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 in reset", {35'd0, busDrive}, 36'd0);
    rstN = 1;
    advN = 0; oeN = 0;
    tick();
    chk("R1 no open burst", {35'd0, busDrive}, 36'd0);
    idle();
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) begin
      adscN = 0; gwN = 0; addr = 6'(i); wrData = pattern(i); oeN = 0;
      tick();
      refMem[i] = pattern(i);
      chk("R9 R5 write edge", {35'd0, busDrive}, 36'd0);
    end
    idle();
  endtask

  task automatic t_linear();
    adspN = 0; gwN = 0; bweN = 0; bwN = 4'h0; wrData = '1; addr = 6'd10;
    tick();
    readChk("R4 adsp read", 10);
    idle(); advN = 0;
    tick(); readChk("R11 beat1", 11);
    tick(); readChk("R11 beat2", 8);
    tick(); readChk("R11 beat3", 9);
    idle();
  endtask

  task automatic t_interleave();
    modeIlv = 1; adspN = 0; addr = 6'd5;
    tick(); readChk("R12 beat0", 5);
    adspN = 1; advN = 0;
    tick(); readChk("R12 beat1", 4);
    tick(); readChk("R12 beat2", 7);
    tick(); readChk("R12 beat3", 6);
    tick(); readChk("R12 wrap", 5);
    idle();
  endtask

  task automatic t_suspend();
    adscN = 0; addr = 6'd9;
    tick(); readChk("R5 adsc read", 9);
    adscN = 1; advN = 1;
    tick(); readChk("R13 hold", 9);
    gwN = 0; wrData = 36'h9_1234_5678;
    tick();
    refMem[9] = 36'h9_1234_5678;
    chk("R9 suspend write", {35'd0, busDrive}, 36'd0);
    gwN = 1;
    tick(); readChk("R13 held write", 9);
    oeN = 1; #1;
    chk("R10 oe off", {35'd0, busDrive}, 36'd0);
    oeN = 0; #1;
    chk("R10 oe on", {35'd0, busDrive}, 36'd1);
    chk("R10 oe data", rdData, refMem[9]);
    idle();
  endtask

  task automatic t_bytes();
    logic [35:0] d;
    adscN = 0; bweN = 0; bwN = 4'b1010; addr = 6'd3; wrData = '1;
    tick();
    chk("R9 partial write", {35'd0, busDrive}, 36'd0);
    d = refMem[3];
    for (int n = 0; n < 4; n++) if (!bwN[n]) begin
      d[8*n +: 8] = 8'hFF; d[32+n] = 1'b1;
    end
    refMem[3] = d;
    bweN = 1; bwN = 4'h0;
    tick(); readChk("R7 R8 lanes 0 2", 3);
    bweN = 0; bwN = 4'hF; wrData = '0;
    tick(); readChk("R8 no lane", 3);
    gwN = 0; bweN = 1; bwN = 4'hF; addr = 6'd6; wrData = 36'hA_BCDE_F012;
    tick();
    refMem[6] = 36'hA_BCDE_F012;
    gwN = 1;
    tick(); readChk("R6 global", 6);
    idle();
  endtask

  task automatic t_priority();
    adspN = 0; adscN = 0; gwN = 0; addr = 6'd7; wrData = '0;
    tick(); readChk("R5 adsp wins", 7);
    idle();
  endtask

  task automatic t_deferred();
    adspN = 0; gwN = 0; addr = 6'd12; wrData = '0;
    tick(); readChk("R4 write ignored", 12);
    adspN = 1; advN = 0; wrData = 36'h5_0F0F_0F0F;
    tick();
    refMem[13] = 36'h5_0F0F_0F0F;
    chk("R14 deferred", {35'd0, busDrive}, 36'd0);
    gwN = 1; advN = 1; adscN = 0; addr = 6'd13;
    tick(); readChk("R14 readback", 13);
    adscN = 0; addr = 6'd12;
    tick(); readChk("R14 start kept", 12);
    idle();
  endtask

  task automatic t_ce1Mask();
    adspN = 0; addr = 6'd0;
    tick(); readChk("R3 start", 0);
    ce1N = 1; advN = 0; addr = 6'd14;
    tick(); readChk("R3 masked", 1);
    idle();
  endtask

  task automatic t_desel();
    adscN = 0; ce2 = 0; addr = 6'd2;
    tick(); chk("R2 desel", {35'd0, busDrive}, 36'd0);
    idle(); advN = 0;
    tick(); chk("R2 stays closed", {35'd0, busDrive}, 36'd0);
    adspN = 0; ce1N = 1;
    tick(); chk("R3 masked idle", {35'd0, busDrive}, 36'd0);
    idle(); adspN = 0; ce3N = 1;
    tick(); chk("R2 ce3 desel", {35'd0, busDrive}, 36'd0);
    idle();
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_fill();
    t_linear();
    t_interleave();
    t_suspend();
    t_bytes();
    t_priority();
    t_deferred();
    t_ce1Mask();
    t_desel();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule